// File: doc/BRIEF.md
# I2C Register-Read Target

This block is the target side of an I2C link that exposes a small bank of 16-bit registers for reading. The controller first writes a command byte that picks one register, then issues a repeated Start with the read bit set. The target answers with the register's upper byte and then its lower byte. As long as the controller acknowledges, the target keeps sending the same pair of bytes.

The selected register number is held in a pointer. The pointer survives across transactions, and after reset it is zero. A command byte whose opcode is not defined is treated as a corrupted transfer. The target then lets go of the data line and stays silent until a fresh Start and a matching control byte arrive.

The register bank sits outside the block. It sees the pointer on `reg_addr` and returns the contents on `reg_data` in the same cycle. SDA is open-drain: the block reads the wired line and asserts `sda_oe` to pull it low. SCL and SDA pass through a two-flop synchronizer before any edge is detected.

Top module: `i2c_regread_target`

## Requirements
- R1: While reset is asserted and straight after it, `sda_oe` is 0 and `reg_addr` is 0.
- R2: The target pulls SDA low in the acknowledge slot of a control byte only when its upper seven bits equal {TARGET_ADDR[6:1], addr_lsb}. Bit 0 of the control byte is R/W, with 1 meaning read. A control byte that does not match gets no acknowledge.
- R3: A command byte with opcode bits [3:2] equal to 2'b11 (read) or 2'b00 (write) is acknowledged. Its bits [7:4] are loaded into the pointer shown on `reg_addr`, and that pointer changes only while SCL is low.
- R4: A command byte with opcode 2'b01 or 2'b10 gets no acknowledge and leaves the pointer unchanged. Every later byte is also left unacknowledged until a new Start.
- R5: After an acknowledged read control byte, the target sends `reg_data[15:8]` and then `reg_data[7:0]`, most significant bit first.
- R6: While the controller acknowledges, the target keeps sending bytes, alternating high byte and low byte of the same register. The pointer does not advance.
- R7: When the controller does not acknowledge a data byte, the target releases SDA and stays released until the next Start.
- R8: A read with no command byte in the same transaction returns the register named by the last accepted command, or register 0 if there has been none since reset.
- R9: `sda_oe` changes only while SCL is low.
- R10: A byte written after an accepted command byte, within the same write phase, is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Wired data line as seen on the bus |
| addr_lsb | input | 1 | Level of the shared pin that supplies address bit 0 |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_addr | output | 4 | Register pointer presented to the register bank |
| reg_data | input | 16 | Contents of the register selected by `reg_addr` |

## Verification
The checks on `sda_oe` and pointer timing assume that every SCL low phase lasts well beyond the synchronizer delay plus one register stage. They also assume that SDA moves only while SCL is low, except at Start and Stop. The bench holds each SCL phase for eight system clocks and changes its own SDA drive only with SCL low. It also issues a Stop or repeated Start only after the target has released the line, that is, after a not-acknowledge or after an unmatched or rejected byte. `addr_lsb` is changed only while the bus is idle.

// File: rtl/i2c_regread_target.sv
module i2c_regread_target #(
  parameter logic [6:0] TARGET_ADDR = 7'h2C,
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             addr_lsb,
  output logic             sda_oe,
  output logic [PTR_W-1:0] reg_addr,
  input  logic [15:0]      reg_data
);

  localparam logic [2:0] ST_IDLE = 3'd0;
  localparam logic [2:0] ST_CTRL = 3'd1;
  localparam logic [2:0] ST_CACK = 3'd2;
  localparam logic [2:0] ST_CMD  = 3'd3;
  localparam logic [2:0] ST_KACK = 3'd4;
  localparam logic [2:0] ST_TX   = 3'd5;
  localparam logic [2:0] ST_RACK = 3'd6;

  logic [2:0] scl_q, sda_q;
  logic [2:0] state;
  logic [3:0] bit_cnt;
  logic [7:0] rx_sh, tx_sh;
  logic       rw, lo_next, m_ack;
  logic [PTR_W-1:0] ptr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end

  wire scl_rise  = scl_q[1] & ~scl_q[2];
  wire scl_fall  = ~scl_q[1] & scl_q[2];
  wire bus_start = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  wire bus_stop  = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
  wire addr_ok   = rx_sh[7:1] == {TARGET_ADDR[6:1], addr_lsb};
  wire cmd_ok    = (rx_sh[3:2] == 2'b11) || (rx_sh[3:2] == 2'b00);
  wire [7:0] next_byte = lo_next ? reg_data[7:0] : reg_data[15:8];

  assign reg_addr = ptr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      rw      <= 1'b0;
      lo_next <= 1'b0;
      m_ack   <= 1'b0;
      ptr     <= '0;
      sda_oe  <= 1'b0;
    end else if (bus_start) begin
      state   <= ST_CTRL;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
    end else if (bus_stop) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: ;
        ST_CTRL, ST_CMD: begin
          if (scl_rise && bit_cnt < 4'd8) begin
            rx_sh   <= {rx_sh[6:0], sda_q[1]};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (scl_fall && bit_cnt == 4'd8) begin
            if (state == ST_CTRL) begin
              if (addr_ok) begin
                sda_oe <= 1'b1;
                rw     <= rx_sh[0];
                state  <= ST_CACK;
              end else
                state <= ST_IDLE;
            end else begin
              if (cmd_ok) begin
                ptr    <= rx_sh[7 -: PTR_W];
                sda_oe <= 1'b1;
                state  <= ST_KACK;
              end else
                state <= ST_IDLE;
            end
          end
        end
        ST_CACK:
          if (scl_fall) begin
            bit_cnt <= '0;
            if (rw) begin
              tx_sh   <= reg_data[15:8];
              sda_oe  <= ~reg_data[15];
              lo_next <= 1'b1;
              state   <= ST_TX;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_CMD;
            end
          end
        ST_KACK:
          if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= ST_IDLE;
          end
        ST_TX:
          if (scl_fall) begin
            if (bit_cnt == 4'd7) begin
              sda_oe <= 1'b0;
              state  <= ST_RACK;
            end else begin
              tx_sh   <= {tx_sh[6:0], 1'b0};
              sda_oe  <= ~tx_sh[6];
              bit_cnt <= bit_cnt + 4'd1;
            end
          end
        ST_RACK:
          if (scl_rise)
            m_ack <= ~sda_q[1];
          else if (scl_fall) begin
            if (m_ack) begin
              tx_sh   <= next_byte;
              sda_oe  <= ~next_byte[7];
              lo_next <= ~lo_next;
              bit_cnt <= '0;
              state   <= ST_TX;
            end else
              state <= ST_IDLE;
          end
        default: state <= ST_IDLE;
      endcase
    end

endmodule

module i2c_regread_target_chk #(
  parameter int PTR_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_i,
  input logic             sda_oe,
  input logic [PTR_W-1:0] reg_addr,
  input logic [2:0]       state
);

  // R1
  reset_release_chk: assert property (@(posedge clk)
    !rst_n |=> (!sda_oe && reg_addr == '0));

  // R9
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_i);

  // R3
  ptr_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != $past(reg_addr)) |-> !scl_i);

  // R4
  idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd0) |-> !sda_oe);

  // R7
  ack_slot_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd6) |-> !sda_oe);

endmodule

bind i2c_regread_target i2c_regread_target_chk #(.PTR_W(PTR_W)) chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .reg_addr(reg_addr), .state(state)
);

// File: tb/i2c_regread_target_test.sv
module i2c_regread_target_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam logic [7:0] CW = 8'h5A;
  localparam logic [7:0] CR = 8'h5B;

  logic clk = 0, rst_n = 0, scl = 1, sda_m = 1, addr_lsb = 1;
  logic sda_oe;
  logic [3:0] reg_addr;
  logic [15:0] reg_data;
  wire sda_line = sda_m & ~sda_oe;
  int checks = 0, failures = 0, oe_hi_moves = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] model(input logic [3:0] a);
    return {a, 4'h5, ~a, a ^ 4'hC};
  endfunction
  assign reg_data = model(reg_addr);

  i2c_regread_target uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .addr_lsb(addr_lsb), .sda_oe(sda_oe), .reg_addr(reg_addr),
    .reg_data(reg_data)
  );

  logic prev_oe = 0;
  always @(negedge clk) begin
    if (rst_n && sda_oe != prev_oe && scl) oe_hi_moves++;
    prev_oe = sda_oe;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1; hw(HALF); scl = 1; hw(HALF); sda_m = 0; hw(HALF); scl = 0; hw(HALF);
  endtask

  task automatic bus_stop;
    sda_m = 0; hw(HALF); scl = 1; hw(HALF); sda_m = 1; hw(HALF);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hw(HALF); scl = 1; hw(HALF); scl = 0;
    end
    sda_m = 1; hw(HALF); scl = 1; hw(HALF/2); acked = ~sda_line; hw(HALF/2); scl = 0;
  endtask

  task automatic read_byte(input bit give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1; hw(HALF); scl = 1; hw(HALF/2); b[i] = sda_line; hw(HALF/2); scl = 0;
    end
    sda_m = give_ack ? 1'b0 : 1'b1; hw(HALF); scl = 1; hw(HALF); scl = 0;
  endtask

  task automatic t_reset;
    check(sda_oe == 0, "R1 sda_oe", sda_oe, 0);
    check(reg_addr == 0, "R1 reg_addr", reg_addr, 0);
  endtask

  task automatic t_read_after_reset;
    bit a; logic [7:0] b;
    bus_start; send_byte(CR, a);
    check(a, "R2 read control ack", a, 1);
    read_byte(1, b); check(b == model(0)[15:8], "R8 hi byte reg0", b, model(0)[15:8]);
    read_byte(0, b); check(b == model(0)[7:0], "R5 lo byte reg0", b, model(0)[7:0]);
    hw(4); check(sda_oe == 0, "R7 released after nack", sda_oe, 0);
    bus_stop;
  endtask

  task automatic t_combined_continuous;
    bit a; logic [7:0] b;
    bus_start; send_byte(CW, a); check(a, "R2 write control ack", a, 1);
    send_byte(8'h3C, a); check(a, "R3 read cmd ack", a, 1);
    check(reg_addr == 3, "R3 pointer", reg_addr, 3);
    bus_start; send_byte(CR, a); check(a, "R2 restart read ack", a, 1);
    for (int k = 0; k < 4; k++) begin
      read_byte(k != 3, b);
      if (k % 2 == 0) check(b == model(3)[15:8], "R6 hi repeat", b, model(3)[15:8]);
      else            check(b == model(3)[7:0], "R6 lo repeat", b, model(3)[7:0]);
    end
    check(reg_addr == 3, "R6 no increment", reg_addr, 3);
    hw(4); check(sda_oe == 0, "R7 released", sda_oe, 0);
    bus_stop;
  endtask

  task automatic t_write_cmd_then_read;
    bit a; logic [7:0] b;
    bus_start; send_byte(CW, a);
    send_byte(8'h71, a); check(a, "R3 write cmd ack", a, 1);
    check(reg_addr == 7, "R3 pointer 7", reg_addr, 7);
    send_byte(8'hAA, a); check(!a, "R10 extra byte nack", a, 0);
    bus_stop;
    bus_start; send_byte(CR, a);
    read_byte(1, b); check(b == model(7)[15:8], "R8 persisted hi", b, model(7)[15:8]);
    read_byte(0, b); check(b == model(7)[7:0], "R8 persisted lo", b, model(7)[7:0]);
    bus_stop;
  endtask

  task automatic t_invalid_cmd;
    bit a; logic [7:0] b;
    bus_start; send_byte(CW, a);
    send_byte(8'h94, a); check(!a, "R4 op01 nack", a, 0);
    check(reg_addr == 7, "R4 pointer kept", reg_addr, 7);
    send_byte(8'h5B, a); check(!a, "R4 silent after bad cmd", a, 0);
    bus_stop;
    bus_start; send_byte(CW, a);
    send_byte(8'hA8, a); check(!a, "R4 op10 nack", a, 0);
    check(reg_addr == 7, "R4 pointer kept op10", reg_addr, 7);
    bus_stop;
    bus_start; send_byte(CR, a); check(a, "R4 recovers on start", a, 1);
    read_byte(0, b); check(b == model(7)[15:8], "R4 reads old reg", b, model(7)[15:8]);
    bus_stop;
  endtask

  task automatic t_address_match;
    bit a; logic [7:0] b;
    bus_start; send_byte(8'h58, a); check(!a, "R2 mismatch nack", a, 0);
    send_byte(8'h5B, a); check(!a, "R2 idle until start", a, 0);
    bus_stop;
    addr_lsb = 0; hw(HALF);
    bus_start; send_byte(8'h59, a); check(a, "R2 lsb pin 0 match", a, 1);
    read_byte(0, b); check(b == model(7)[15:8], "R5 hi with lsb 0", b, model(7)[15:8]);
    bus_stop;
    bus_start; send_byte(CR, a); check(!a, "R2 lsb pin 0 rejects 1", a, 0);
    bus_stop;
    addr_lsb = 1; hw(HALF);
  endtask

  initial begin
    hw(5);
    t_reset;
    rst_n = 1; hw(5);
    t_reset;
    t_read_after_reset;
    t_combined_continuous;
    t_write_cmd_then_read;
    t_invalid_cmd;
    t_address_match;
    check(oe_hi_moves == 0, "R9 oe moves with scl high", oe_hi_moves, 0);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule